// File: doc/BRIEF.md
# Flash Read Line Buffer

This block sits between a processor read port and a slow non-volatile memory array. It answers byte, halfword and word reads. For each bank, and separately for instruction and data fetches, software can choose buffered or unbuffered operation.

In buffered mode, a read that misses causes one fetch of the whole aligned 16-byte line. That fetch is stalled by the configured number of wait states. The line and its tag are then kept in a register owned by that bank and that fetch type. Any later read of the same type into the same line is answered on the next cycle with no stall and without touching the array.

In unbuffered mode every read goes to the array at its own width, pays the wait states, and leaves the line registers alone. Two 32-bit counters record array fetches, one for instruction fetches and one for data fetches, so that software can tune the buffer and wait-state settings. The array is a behavioural model: the 32-bit word at word index w holds (w × 0x9E3779B1) XOR 0x5A5A0F0F.

Top module: `flash_line_buf`

## Requirements
- R1: A buffered read whose line address (addr[15:4]) matches the valid line held for its bank and fetch type is answered with rsp_valid in the cycle after acceptance. req_ready stays high and neither counter changes.
- R2: A buffered read that misses fetches the whole aligned line and answers after cfg_wait extra cycles (cfg_wait is 0 to 3). The line is kept, so later reads of the same type anywhere in that line hit.
- R3: An unbuffered read always fetches from the array. It stalls cfg_wait extra cycles, increments its counter every time, and does not fill a line register.
- R4: The bank is req_addr[15] (0 or 1). cfg_ibuf_en[b] and cfg_dbuf_en[b] enable buffering for instruction (req_instr=1) and data (req_instr=0) fetches of bank b. Each bank and type pair has its own line register, so a fill for one pair never makes another pair hit.
- R5: req_size is 0 for a byte, 1 for a halfword and 2 for a word. A byte is taken from bits [8·addr[1:0] +: 8] of the addressed word and a halfword from bits [16·addr[1] +: 16]. Both are zero-extended on rsp_data.
- R6: A read with req_size 3, a halfword with addr[0]=1, or a word with addr[1:0]≠0 is answered in the next cycle with rsp_err=1 and rsp_data=0. It causes no array fetch and no count.
- R7: cnt_instr and cnt_data increment once per array fetch of their type and never on a hit. They wrap at 2^32. A cycle with cnt_clr=1 clears both on the next edge, and the clear takes priority over an increment.
- R8: Changing either enable of bank b invalidates both line registers of bank b. Changing cfg_wait invalidates all line registers. A lookup in the cycle of the change is treated as a miss.
- R9: After reset, req_ready=1, rsp_valid=0 and both counters are 0. While a fetch is stalled, req_ready=0 and rsp_valid=0, and a response follows in the cycle where req_ready returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 16 | Byte address; bit 15 selects the bank |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| req_instr | input | 1 | 1 for an instruction fetch, 0 for a data fetch |
| req_ready | output | 1 | Request accepted on this edge when high |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Zero-extended read data |
| rsp_err | output | 1 | Misaligned or illegal-size request |
| cfg_ibuf_en | input | 2 | Per-bank instruction buffering enable |
| cfg_dbuf_en | input | 2 | Per-bank data buffering enable |
| cfg_wait | input | 2 | Wait states for array fetches |
| cnt_clr | input | 1 | Clear both fetch counters |
| cnt_instr | output | 32 | Instruction array fetch count |
| cnt_data | output | 32 | Data array fetch count |

## Verification
The hardest situation to reach is a stale line that ought to have been invalidated. To see it, a line must be filled, then a configuration change must touch only the other bank, or only the wait field, and then the same line must be read again. Directed steps build exactly this sequence, and the observed stall and counter step separate a hit from a miss. Random traffic then draws addresses from a pool of four lines per bank and changes the configuration at random intervals, so hits, invalidations and mixed widths interleave against the bench's own line model.

// File: rtl/flash_lbuf_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the flash read line buffer.
// Assumes 32-bit words and little-endian lane numbering.
package flash_lbuf_pkg;
    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} size_e;

    // Content of the behavioural array at a given word index.
    function automatic logic [31:0] cell_word(input logic [31:0] widx);
        return (widx * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    // Pick the addressed lane out of a word and zero-extend it.
    function automatic logic [31:0] lane_of(input logic [31:0] w, input logic [1:0] a, input logic [1:0] s);
        case (s)
            SZ_BYTE: return {24'b0, w[{a, 3'b000} +: 8]};
            SZ_HALF: return {16'b0, w[{a[1], 4'b0000} +: 16]};
            SZ_WORD: return w;
            default: return 32'b0;
        endcase
    endfunction

    // True when the width/alignment combination is illegal.
    function automatic logic is_bad(input logic [1:0] a, input logic [1:0] s);
        return (s == SZ_BAD) || (s == SZ_HALF && a[0]) || (s == SZ_WORD && a != 2'b00);
    endfunction
endpackage

// File: rtl/flash_array_model.sv
`timescale 1ns/1ps
// Behavioural non-volatile array. Provides a whole line read and a
// single word read, both combinational; the controller applies wait states.
// Assumes ADDR_W-2 <= 32.
module flash_array_model #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 128,
    localparam int WPL    = LINE_W / 32,
    localparam int WSEL_W = $clog2(WPL),
    localparam int OFF_W  = $clog2(LINE_W / 8),
    localparam int TAG_W  = ADDR_W - OFF_W
) (
    input  logic [TAG_W-1:0]  line_idx,
    input  logic [ADDR_W-3:0] word_idx,
    output logic [LINE_W-1:0] line_q,
    output logic [31:0]       word_q
);
    import flash_lbuf_pkg::*;

    // One word of the line per generated slice.
    for (genvar j = 0; j < WPL; j++) begin : g_word
        localparam logic [WSEL_W-1:0] JS = WSEL_W'(j);
        assign line_q[j*32 +: 32] = cell_word(32'({line_idx, JS}));
    end

    // Narrow (bypass) read of a single word.
    assign word_q = cell_word(32'(word_idx));
endmodule

// File: rtl/flash_lbuf_line.sv
`timescale 1ns/1ps
// One line register: data, tag and valid. Clear has priority over load.
module flash_lbuf_line #(
    parameter int TAG_W  = 12,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [TAG_W-1:0]  tag_d,
    input  logic [LINE_W-1:0] line_d,
    output logic              valid_q,
    output logic [TAG_W-1:0]  tag_q,
    output logic [LINE_W-1:0] line_q
);
    // Valid bit: cleared on reset or invalidate, set on fill.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) valid_q <= 1'b0;
        else if (load)     valid_q <= 1'b1;
    end

    // Tag and data captured on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            line_q <= '0;
        end else if (load && !clr) begin
            tag_q  <= tag_d;
            line_q <= line_d;
        end
    end
endmodule

// File: rtl/flash_lbuf_cnt.sv
`timescale 1ns/1ps
// Instruction and data fetch counters; wrap naturally, clear has priority.
module flash_lbuf_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_i,
    input  logic             inc_d,
    output logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_d
);
    // Count array fetches by type.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_i <= '0;
            cnt_d <= '0;
        end else begin
            if (inc_i) cnt_i <= cnt_i + 1'b1;
            if (inc_d) cnt_d <= cnt_d + 1'b1;
        end
    end
endmodule

// File: rtl/flash_line_buf.sv
`timescale 1ns/1ps
// Flash read line buffer. Accepts one read at a time (req_ready), answers
// hits and illegal requests on the next cycle, and stalls array fetches for
// cfg_wait cycles (0 wait states answer on the next cycle too).
// Assumes configuration inputs only change between accesses.
module flash_line_buf #(
    parameter int ADDR_W = 16,
    parameter int WS_W   = 2,
    parameter int CNT_W  = 32,
    localparam int NBANK  = 2,
    localparam int LINE_W = 128,
    localparam int OFF_W  = $clog2(LINE_W / 8),
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int NLINE  = NBANK * 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_instr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              rsp_err,
    input  logic [NBANK-1:0]  cfg_ibuf_en,
    input  logic [NBANK-1:0]  cfg_dbuf_en,
    input  logic [WS_W-1:0]   cfg_wait,
    input  logic              cnt_clr,
    output logic [CNT_W-1:0]  cnt_instr,
    output logic [CNT_W-1:0]  cnt_data
);
    import flash_lbuf_pkg::*;

    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e               st_q;
    logic [WS_W-1:0]   ws_cnt_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [1:0]        pend_size_q;
    logic              pend_instr_q;
    logic              pend_buf_q;
    logic [NBANK-1:0]  ien_q, den_q;
    logic [WS_W-1:0]   ws_q;
    logic [NBANK-1:0]  bank_clr;

    logic              acc, bad, buf_on, hit, fetch_go, finish, fill;
    logic              bank;
    logic [1:0]        idx, fill_idx;
    logic [ADDR_W-1:0] cur_addr;
    logic [1:0]        cur_size;
    logic              cur_buf;
    logic [LINE_W-1:0] arr_line;
    logic [31:0]       arr_word;
    logic [31:0]       fetch_data;
    logic [31:0]       hit_word;

    logic [NLINE-1:0]  lv;
    logic [TAG_W-1:0]  ltag  [NLINE];
    logic [LINE_W-1:0] ldata [NLINE];

    // Request decode.
    assign req_ready = (st_q == ST_IDLE);
    assign acc       = req_valid && req_ready;
    assign bad       = is_bad(req_addr[1:0], req_size);
    assign bank      = req_addr[ADDR_W-1];
    assign idx       = {bank, req_instr};
    assign buf_on    = req_instr ? cfg_ibuf_en[bank] : cfg_dbuf_en[bank];
    assign hit       = buf_on && lv[idx] && !bank_clr[bank] &&
                       (ltag[idx] == req_addr[ADDR_W-1:OFF_W]);
    assign fetch_go  = acc && !bad && !hit;

    // Configuration change detection per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bclr
        assign bank_clr[b] = (cfg_ibuf_en[b] != ien_q[b]) || (cfg_dbuf_en[b] != den_q[b]) ||
                             (cfg_wait != ws_q);
    end

    // Remember the configuration seen on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
            den_q <= '0;
            ws_q  <= '0;
        end else begin
            ien_q <= cfg_ibuf_en;
            den_q <= cfg_dbuf_en;
            ws_q  <= cfg_wait;
        end
    end

    // Array access address: live request when idle, pending one when stalled.
    assign cur_addr = (st_q == ST_WAIT) ? pend_addr_q  : req_addr;
    assign cur_size = (st_q == ST_WAIT) ? pend_size_q  : req_size;
    assign cur_buf  = (st_q == ST_WAIT) ? pend_buf_q   : buf_on;

    flash_array_model #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_arr (
        .line_idx (cur_addr[ADDR_W-1:OFF_W]),
        .word_idx (cur_addr[ADDR_W-1:2]),
        .line_q   (arr_line),
        .word_q   (arr_word)
    );

    // Fetch completion and line fill control.
    assign finish   = (st_q == ST_IDLE) ? (fetch_go && cfg_wait == '0)
                                        : (ws_cnt_q == WS_W'(1));
    assign fill     = finish && cur_buf;
    assign fill_idx = (st_q == ST_WAIT) ? {pend_addr_q[ADDR_W-1], pend_instr_q} : idx;

    // Data for a completing fetch: lane from full line or from narrow word.
    always_comb begin
        if (cur_buf) fetch_data = lane_of(arr_line[{cur_addr[OFF_W-1:2], 5'b00000} +: 32],
                                          cur_addr[1:0], cur_size);
        else         fetch_data = lane_of(arr_word, cur_addr[1:0], cur_size);
    end

    // Lane from the held line on a hit.
    assign hit_word = lane_of(ldata[idx][{req_addr[OFF_W-1:2], 5'b00000} +: 32],
                              req_addr[1:0], req_size);

    // Line registers, one per bank and fetch type.
    for (genvar i = 0; i < NLINE; i++) begin : g_line
        flash_lbuf_line #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (bank_clr[i/2]),
            .load    (fill && fill_idx == 2'(i)),
            .tag_d   (cur_addr[ADDR_W-1:OFF_W]),
            .line_d  (arr_line),
            .valid_q (lv[i]),
            .tag_q   (ltag[i]),
            .line_q  (ldata[i])
        );
    end

    // Control state: idle or counting down wait states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            ws_cnt_q     <= '0;
            pend_addr_q  <= '0;
            pend_size_q  <= '0;
            pend_instr_q <= 1'b0;
            pend_buf_q   <= 1'b0;
        end else if (st_q == ST_IDLE) begin
            if (fetch_go && cfg_wait != '0) begin
                st_q         <= ST_WAIT;
                ws_cnt_q     <= cfg_wait;
                pend_addr_q  <= req_addr;
                pend_size_q  <= req_size;
                pend_instr_q <= req_instr;
                pend_buf_q   <= buf_on;
            end
        end else begin
            if (ws_cnt_q == WS_W'(1)) st_q <= ST_IDLE;
            ws_cnt_q <= ws_cnt_q - 1'b1;
        end
    end

    // Response register: one pulse per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            if (acc && bad) begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b1;
                rsp_data  <= '0;
            end else if (acc && hit) begin
                rsp_valid <= 1'b1;
                rsp_data  <= hit_word;
            end else if (finish) begin
                rsp_valid <= 1'b1;
                rsp_data  <= fetch_data;
            end
        end
    end

    flash_lbuf_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc_i (fetch_go && req_instr),
        .inc_d (fetch_go && !req_instr),
        .cnt_i (cnt_instr),
        .cnt_d (cnt_data)
    );
endmodule

// File: rtl/flash_lbuf_chk.sv
`timescale 1ns/1ps
// Property checker for flash_line_buf, attached with bind below.
module flash_lbuf_chk #(
    parameter int ADDR_W = 16,
    parameter int WS_W   = 2,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_data,
    input logic [WS_W-1:0]   cfg_wait,
    input logic              cnt_clr,
    input logic [CNT_W-1:0]  cnt_instr,
    input logic [CNT_W-1:0]  cnt_data,
    input logic              hit
);
    logic ill;
    assign ill = (req_size == 2'd3) || (req_size == 2'd1 && req_addr[0]) ||
                 (req_size == 2'd2 && req_addr[1:0] != 2'b00);

    p_hit_nocount_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit && !cnt_clr) |=> ($stable(cnt_instr) && $stable(cnt_data) && rsp_valid && req_ready));

    p_ws0_nostall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && cfg_wait == '0) |=> req_ready);

    p_resume_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> rsp_valid);

    p_err_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ill) |=> (rsp_valid && rsp_err && rsp_data == 32'd0));

    p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> rsp_data == 32'd0);

    p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_instr == '0 && cnt_data == '0));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ((cnt_instr == $past(cnt_instr) || cnt_instr == $past(cnt_instr) + 1'b1) &&
                      (cnt_data == $past(cnt_data) || cnt_data == $past(cnt_data) + 1'b1)));

    p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !rsp_valid);
endmodule

bind flash_line_buf flash_lbuf_chk #(.ADDR_W(ADDR_W), .WS_W(WS_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .cfg_wait  (cfg_wait),
    .cnt_clr   (cnt_clr),
    .cnt_instr (cnt_instr),
    .cnt_data  (cnt_data),
    .hit       (hit)
);

// File: tb/sim_flash_line_buf.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random reads, all
// compared against an independent line/counter model.
module sim_flash_line_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_instr = 1'b0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_data;
    logic [1:0]  cfg_ibuf_en = '0, cfg_dbuf_en = '0;
    logic [1:0]  cfg_wait = '0;
    logic        cnt_clr = 1'b0;
    logic [31:0] cnt_instr, cnt_data;

    int n_chk = 0, n_fail = 0;
    bit mv [2][2];
    logic [11:0] mt [2][2];
    logic [31:0] e_ci = 0, e_cd = 0;

    always #2.5 clk = ~clk;

    flash_line_buf u0 (.*);

    task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] w);
        return (w * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic bit illegal(input logic [15:0] a, input logic [1:0] s);
        return s == 2'd3 || (s == 2'd1 && a[0]) || (s == 2'd2 && a[1:0] != 0);
    endfunction

    function automatic logic [31:0] exp_data(input logic [15:0] a, input logic [1:0] s);
        logic [31:0] w = mem_word(32'(a[15:2]));
        case (s)
            2'd0: return (w >> (8 * a[1:0])) & 32'hFF;
            2'd1: return (w >> (16 * a[1])) & 32'hFFFF;
            2'd2: return w;
            default: return 0;
        endcase
    endfunction

    task automatic set_cfg(input logic [1:0] ei, input logic [1:0] ed, input logic [1:0] ws);
        @(negedge clk);
        for (int b = 0; b < 2; b++)
            if (ei[b] != cfg_ibuf_en[b] || ed[b] != cfg_dbuf_en[b] || ws != cfg_wait) begin
                mv[b][0] = 0; mv[b][1] = 0;
            end
        cfg_ibuf_en = ei; cfg_dbuf_en = ed; cfg_wait = ws;
        @(negedge clk);
    endtask

    // Issue one read, measure stall, compare against the model.
    task automatic rd(input logic [15:0] a, input logic [1:0] s, input bit ins, input string force_tag);
        int stall; bit rdy1; bit on, hit, ill; int bk;
        string tg;
        bk = a[15]; ill = illegal(a, s);
        on = ins ? cfg_ibuf_en[bk] : cfg_dbuf_en[bk];
        hit = on && mv[bk][ins] && mt[bk][ins] == a[15:4];
        @(negedge clk);
        req_addr = a; req_size = s; req_instr = ins; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rdy1 = req_ready;
        stall = 0;
        while (!rsp_valid && stall < 20) begin stall++; @(negedge clk); end
        if (!ill && !hit) begin
            if (ins) e_ci++; else e_cd++;
            if (on) begin mv[bk][ins] = 1; mt[bk][ins] = a[15:4]; end
        end
        tg = force_tag != "" ? force_tag : ill ? "R6" : hit ? "R1" : on ? "R2" : "R3";
        chk(rsp_err == ill, tg, "err", rsp_err, ill);
        chk(rsp_data == (ill ? 32'd0 : exp_data(a, s)), ill ? "R6" : "R5", "data", rsp_data,
            ill ? 0 : exp_data(a, s));
        chk(stall == ((ill || hit) ? 0 : int'(cfg_wait)), tg, "stall", stall,
            (ill || hit) ? 0 : cfg_wait);
        chk(rdy1 == (stall == 0), "R9", "ready after accept", rdy1, stall == 0);
        chk(cnt_instr == e_ci && cnt_data == e_cd, "R7", "counters",
            {cnt_instr, cnt_data}, {e_ci, e_cd});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h0BADF00D);
        for (int b = 0; b < 2; b++) for (int t = 0; t < 2; t++) begin mv[b][t] = 0; mt[b][t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1 && rsp_valid == 0, "R9", "reset handshake", {req_ready, rsp_valid}, 2'b10);
        chk(cnt_instr == 0 && cnt_data == 0, "R9", "reset counters", {cnt_instr, cnt_data}, 0);

        // R2 miss then R1 hits with wait states 2
        set_cfg(2'b11, 2'b11, 2'd2);
        rd(16'h0010, 2'd2, 1, "R2");
        rd(16'h0014, 2'd1, 1, "R1");
        rd(16'h001F, 2'd0, 1, "R5");
        // R4 data line is separate from the instruction line
        rd(16'h0010, 2'd2, 0, "R4");
        // R3 bypass in bank 1 only; bank 0 keeps its lines (R4)
        set_cfg(2'b01, 2'b11, 2'd2);
        rd(16'h8010, 2'd2, 1, "R3");
        rd(16'h8010, 2'd2, 1, "R3");
        rd(16'h0018, 2'd2, 1, "R4");
        // R6 illegal requests
        rd(16'h0011, 2'd1, 1, "R6");
        rd(16'h0012, 2'd2, 0, "R6");
        rd(16'h0000, 2'd3, 0, "R6");
        // R8 wait-state change invalidates everything
        set_cfg(2'b01, 2'b11, 2'd3);
        rd(16'h0010, 2'd2, 1, "R8");
        rd(16'h0014, 2'd2, 1, "R1");
        // R2 with zero wait states: no stall even on a miss
        set_cfg(2'b01, 2'b11, 2'd0);
        rd(16'h0020, 2'd0, 0, "R2");
        // R7 counter clear
        @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
        e_ci = 0; e_cd = 0;
        chk(cnt_instr == 0 && cnt_data == 0, "R7", "clear", {cnt_instr, cnt_data}, 0);

        // Random phase
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a; logic [1:0] s;
            if ($urandom_range(0, 24) == 0)
                set_cfg(2'($urandom), 2'($urandom), 2'($urandom));
            a = {1'($urandom), 9'b0, 2'($urandom), 4'($urandom)};
            s = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            if ($urandom_range(0, 3) != 0) begin
                if (s == 2'd1) a[0] = 0;
                if (s == 2'd2) a[1:0] = 0;
            end
            rd(a, s, 1'($urandom), "");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule